// File: doc/BRIEF.md
# GF(32) Exponent and Tuple Arithmetic Unit

This block performs arithmetic on elements of the 32-element Galois field generated by x^5 + x^2 + 1, for use inside a multi-error BCH decoder. Each element is carried in one of two forms: an exponent k (the element is alpha^k, k in 0..30, with a separate flag for the zero element) or a 5-bit tuple (the polynomial coefficients of the element). Multiplication and division are done by adding or subtracting exponents modulo 31; addition is done by XOR of tuples. The unit also converts each form into the other.

One operation is accepted per clock when the valid strobe is high. The result is registered and presented in both forms, together with a zero flag and a divide-by-zero flag, one clock later. The modulo-31 reduction uses a single compare-and-correct step instead of a general modulus operator, and the two conversions use a field table built at elaboration time from the field polynomial.

Top module: `gf32_alu`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted operation, valid_o, res_exp_o, res_tup_o, res_zero_o and div_err_o are all 0.
- R2: An operation accepted with valid_i high appears on the outputs with valid_o high one clock later; in a cycle where valid_i is low, valid_o is low in the next cycle and the four result outputs keep their values.
- R3: Operation code 0 (multiply) with both zero flags low gives exponent (a + b) mod 31, for example 5 and 11 give 16; res_tup_o is the tuple of that exponent.
- R4: Operation code 1 (divide) with both zero flags low gives exponent (a - b) mod 31 and its tuple.
- R5: Operation code 2 (add) treats a_i and b_i as tuples, ignores both zero flags, gives res_tup_o = a_i XOR b_i and res_exp_o = its exponent; an all-zero XOR gives res_zero_o = 1.
- R6: Operation code 3 (log) treats a_i as a tuple and gives its exponent; a_i = 0 gives res_zero_o = 1.
- R7: Operation code 4 (antilog) gives the tuple of exponent a_i; the tuple bit 4 is the alpha^4 coefficient and bit 0 the alpha^0 coefficient, so exponent 5 gives 5'b00101 and exponent 7 gives 5'b10100; a_zero_i high gives res_zero_o = 1.
- R8: An exponent input of 31 is taken as 0, so antilog of 31 gives 5'b00001 and multiply by alpha^31 leaves the other operand unchanged.
- R9: Multiply with either zero flag high, or divide with a_zero_i high and b_zero_i low, gives res_zero_o = 1, res_exp_o = 0, res_tup_o = 0 and div_err_o = 0.
- R10: Divide with b_zero_i high gives div_err_o = 1 and res_zero_o = 1; no other operation sets div_err_o.
- R11: Operation codes 5 to 7 give res_zero_o = 1, res_exp_o = 0, res_tup_o = 0 and div_err_o = 0.
- R12: res_exp_o is never above 30, and whenever res_zero_o is low res_tup_o is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code: 0 mul, 1 div, 2 add, 3 log, 4 antilog |
| a_i | input | 5 | First operand (exponent or tuple by operation) |
| b_i | input | 5 | Second operand (exponent or tuple by operation) |
| a_zero_i | input | 1 | First operand is the zero element (exponent operations) |
| b_zero_i | input | 1 | Second operand is the zero element (exponent operations) |
| valid_o | output | 1 | Result strobe |
| res_exp_o | output | 5 | Result exponent, 0..30 |
| res_tup_o | output | 5 | Result tuple |
| res_zero_o | output | 1 | Result is the zero element |
| div_err_o | output | 1 | Division by zero |

## Verification
The assertions assume only that operation codes and operands are two-state values presented with valid_i, so that the zero-flag and range properties can hold for every code including the unused ones; exponent inputs of 31 are allowed and must reduce to 0. The stimulus therefore sweeps every exponent pair 0..30 for multiply and divide, every tuple pair for add, every input value including 31 for the conversions, and the unused codes, inserting idle cycles with changed operands to show that results hold.

// File: rtl/gf32_pkg.sv
package gf32_pkg;
  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_DIV  = 3'd1,
    OP_ADD  = 3'd2,
    OP_LOG  = 3'd3,
    OP_ALOG = 3'd4
  } gf_op_e;
endpackage

// File: rtl/gf_field_table.sv
// Power table alpha^0 .. alpha^(N-1) in tuple form, built at elaboration.
module gf_field_table #(
  parameter int unsigned M    = 5,
  parameter logic [M-1:0] POLY = 5'b00101,
  localparam int unsigned N = (1 << M) - 1
) (
  output logic [M-1:0] tab_o [N]
);
  function automatic logic [M-1:0] alpha_pow(int unsigned k);
    logic [M-1:0] t;
    t = {{(M-1){1'b0}}, 1'b1};
    for (int unsigned i = 0; i < k; i++) begin
      t = t[M-1] ? ((t << 1) ^ POLY) : (t << 1);
    end
    return t;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_pow
    assign tab_o[g] = alpha_pow(g);
  end
endmodule

// File: rtl/gf_exp_modsum.sv
// Exponent add or subtract modulo N with one compare-and-correct step.
// Inputs must already lie in 0..N-1.
module gf_exp_modsum #(
  parameter int unsigned M = 5,
  localparam int unsigned N = (1 << M) - 1
) (
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  input  logic         sub_i,
  output logic [M-1:0] r_o
);
  localparam logic [M:0] NW = (M+1)'(N);
  logic [M:0] raw;
  logic [M:0] fix;

  always_comb begin
    if (!sub_i) begin
      raw = {1'b0, a_i} + {1'b0, b_i};
      fix = (raw >= NW) ? raw - NW : raw;
    end else begin
      raw = {1'b0, a_i} - {1'b0, b_i};
      fix = (a_i >= b_i) ? raw : raw + NW;
    end
  end

  assign r_o = fix[M-1:0];
endmodule

// File: rtl/gf_log_lookup.sv
// Tuple to exponent by search of the power table; zero tuple gives 0.
module gf_log_lookup #(
  parameter int unsigned M = 5,
  localparam int unsigned N = (1 << M) - 1
) (
  input  logic [M-1:0] tab_i [N],
  input  logic [M-1:0] tup_i,
  output logic [M-1:0] exp_o
);
  always_comb begin
    exp_o = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (tab_i[i] == tup_i) exp_o = M'(i);
    end
  end
endmodule

// File: rtl/gf32_alu.sv
module gf32_alu
  import gf32_pkg::*;
#(
  parameter int unsigned M    = 5,
  parameter logic [M-1:0] POLY = 5'b00101
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [2:0]   op_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  input  logic         a_zero_i,
  input  logic         b_zero_i,
  output logic         valid_o,
  output logic [M-1:0] res_exp_o,
  output logic [M-1:0] res_tup_o,
  output logic         res_zero_o,
  output logic         div_err_o
);
  localparam int unsigned N = (1 << M) - 1;
  localparam logic [M-1:0] NMAX = M'(N);

  logic [M-1:0] tab [N];
  logic [M-1:0] a_e, b_e, sum_e, log_e, tup_src;
  logic [M-1:0] nx_exp, nx_tup;
  logic         nx_zero, nx_err;
  gf_op_e       op;

  assign op = gf_op_e'(op_i);

  // exponent 31 is alpha^0
  assign a_e = (a_i == NMAX) ? '0 : a_i;
  assign b_e = (b_i == NMAX) ? '0 : b_i;
  assign tup_src = (op == OP_ADD) ? (a_i ^ b_i) : a_i;

  gf_field_table #(.M(M), .POLY(POLY)) u_tab (.tab_o(tab));

  gf_exp_modsum #(.M(M)) u_modsum (
    .a_i  (a_e),
    .b_i  (b_e),
    .sub_i(op == OP_DIV),
    .r_o  (sum_e)
  );

  gf_log_lookup #(.M(M)) u_log (
    .tab_i(tab),
    .tup_i(tup_src),
    .exp_o(log_e)
  );

  always_comb begin
    nx_err  = 1'b0;
    nx_zero = 1'b1;
    nx_exp  = '0;
    nx_tup  = '0;
    case (op)
      OP_MUL, OP_DIV: begin
        nx_zero = a_zero_i | b_zero_i;
        nx_err  = (op == OP_DIV) & b_zero_i;
        nx_exp  = sum_e;
        nx_tup  = tab[sum_e];
      end
      OP_ADD, OP_LOG: begin
        nx_zero = (tup_src == '0);
        nx_exp  = log_e;
        nx_tup  = tup_src;
      end
      OP_ALOG: begin
        nx_zero = a_zero_i;
        nx_exp  = a_e;
        nx_tup  = tab[a_e];
      end
      default: ;
    endcase
    if (nx_zero) begin
      nx_exp = '0;
      nx_tup = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      res_exp_o  <= '0;
      res_tup_o  <= '0;
      res_zero_o <= 1'b0;
      div_err_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_exp_o  <= nx_exp;
        res_tup_o  <= nx_tup;
        res_zero_o <= nx_zero;
        div_err_o  <= nx_err;
      end
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_exp_o) && $stable(res_tup_o)
                  && $stable(res_zero_o) && $stable(div_err_o)));
  // R9
  mul_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0 && (a_zero_i || b_zero_i)) |=> (res_zero_o && !div_err_o));
  // R10
  div_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> res_zero_o);
  // R10
  div_err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 3'd1) |=> !div_err_o);
  // R12
  exp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_exp_o <= M'(N - 1));
  // R12
  nonzero_tup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_zero_o && valid_o |-> res_tup_o != '0);
  // R9
  zero_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_zero_o |-> (res_exp_o == '0 && res_tup_o == '0));
endmodule

// File: tb/gf32_alu_tb.sv
`timescale 1ns/1ps
module gf32_alu_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [4:0] a_i = '0, b_i = '0;
  logic       a_zero_i = 1'b0, b_zero_i = 1'b0;
  logic       valid_o, res_zero_o, div_err_o;
  logic [4:0] res_exp_o, res_tup_o;

  int checks = 0;
  int errors = 0;
  logic [4:0] pw [31];

  always #4 clk_i = ~clk_i;

  gf32_alu u_dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i, .a_zero_i, .b_zero_i,
    .valid_o, .res_exp_o, .res_tup_o, .res_zero_o, .div_err_o
  );

  function automatic logic [4:0] log_of(logic [4:0] t);
    for (int i = 0; i < 31; i++) if (pw[i] == t) return 5'(i);
    return 5'd0;
  endfunction

  // {valid, zero, err, exp, tup}
  function automatic logic [12:0] model(logic [2:0] op, logic [4:0] a, logic [4:0] b,
                                        logic az, logic bz);
    int ae, be, e;
    logic [4:0] t;
    logic z, er;
    ae = (a == 5'd31) ? 0 : int'(a);
    be = (b == 5'd31) ? 0 : int'(b);
    er = 1'b0; z = 1'b1; e = 0; t = '0;
    case (op)
      3'd0: begin z = az | bz; e = (ae + be) % 31; t = pw[e]; end
      3'd1: begin z = az | bz; er = bz; e = (ae - be + 31) % 31; t = pw[e]; end
      3'd2: begin t = a ^ b; z = (t == 0); e = int'(log_of(t)); end
      3'd3: begin t = a; z = (t == 0); e = int'(log_of(t)); end
      3'd4: begin z = az; e = ae; t = pw[e]; end
      default: ;
    endcase
    if (z) begin e = 0; t = '0; end
    return {1'b1, z, er, 5'(e), t};
  endfunction

  function automatic logic [12:0] outs();
    return {valid_o, res_zero_o, div_err_o, res_exp_o, res_tup_o};
  endfunction

  task automatic chk(string req, logic [12:0] got, logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic run_op(string req, logic [2:0] op, logic [4:0] a, logic [4:0] b,
                        logic az, logic bz);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; a_zero_i = az; b_zero_i = bz;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(req, outs(), model(op, a, b, az, bz));
  endtask

  task automatic t_reset();
    // R1
    chk("R1", outs(), 13'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", outs(), 13'd0);
  endtask

  task automatic t_mul();
    run_op("R3", 3'd0, 5'd5, 5'd11, 1'b0, 1'b0);
    chk("R3", {res_exp_o, res_tup_o}, {5'd16, pw[16]});
    for (int a = 0; a < 31; a++)
      for (int b = 0; b < 31; b++) run_op("R3", 3'd0, 5'(a), 5'(b), 1'b0, 1'b0);
  endtask

  task automatic t_div();
    run_op("R4", 3'd1, 5'd3, 5'd7, 1'b0, 1'b0);
    chk("R4", {res_exp_o, res_tup_o}, {5'd27, pw[27]});
    for (int a = 0; a < 31; a++)
      for (int b = 0; b < 31; b++) run_op("R4", 3'd1, 5'(a), 5'(b), 1'b0, 1'b0);
  endtask

  task automatic t_add();
    run_op("R5", 3'd2, 5'b10100, 5'b10100, 1'b1, 1'b1);
    chk("R5", {res_zero_o, res_tup_o}, {1'b1, 5'd0});
    run_op("R5", 3'd2, 5'b10000, 5'b00100, 1'b0, 1'b0);
    chk("R5", res_exp_o, 5'd7);
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++) run_op("R5", 3'd2, 5'(a), 5'(b), a[0], b[1]);
  endtask

  task automatic t_log();
    run_op("R6", 3'd3, 5'd0, 5'd0, 1'b0, 1'b0);
    chk("R6", res_zero_o, 1'b1);
    for (int a = 0; a < 32; a++) run_op("R6", 3'd3, 5'(a), 5'd9, 1'b0, 1'b0);
  endtask

  task automatic t_alog();
    run_op("R7", 3'd4, 5'd5, 5'd0, 1'b0, 1'b0);
    chk("R7", res_tup_o, 5'b00101);
    run_op("R7", 3'd4, 5'd7, 5'd0, 1'b0, 1'b0);
    chk("R7", res_tup_o, 5'b10100);
    run_op("R7", 3'd4, 5'd4, 5'd0, 1'b1, 1'b0);
    chk("R7", {res_zero_o, res_tup_o}, {1'b1, 5'd0});
    for (int a = 0; a < 32; a++) run_op("R7", 3'd4, 5'(a), 5'd0, 1'b0, 1'b0);
  endtask

  task automatic t_wrap();
    // R8
    run_op("R8", 3'd4, 5'd31, 5'd0, 1'b0, 1'b0);
    chk("R8", {res_exp_o, res_tup_o}, {5'd0, 5'b00001});
    run_op("R8", 3'd0, 5'd31, 5'd13, 1'b0, 1'b0);
    chk("R8", res_exp_o, 5'd13);
  endtask

  task automatic t_zero();
    // R9
    run_op("R9", 3'd0, 5'd4, 5'd9, 1'b1, 1'b0);
    chk("R9", {res_zero_o, div_err_o, res_exp_o, res_tup_o}, 12'h800);
    run_op("R9", 3'd0, 5'd4, 5'd9, 1'b0, 1'b1);
    run_op("R9", 3'd1, 5'd4, 5'd9, 1'b1, 1'b0);
    chk("R9", div_err_o, 1'b0);
  endtask

  task automatic t_div0();
    // R10
    run_op("R10", 3'd1, 5'd6, 5'd2, 1'b0, 1'b1);
    chk("R10", {res_zero_o, div_err_o}, 2'b11);
    run_op("R10", 3'd1, 5'd6, 5'd2, 1'b1, 1'b1);
    chk("R10", div_err_o, 1'b1);
    run_op("R10", 3'd0, 5'd6, 5'd2, 1'b0, 1'b1);
    chk("R10", div_err_o, 1'b0);
  endtask

  task automatic t_badop();
    // R11
    for (int op = 5; op < 8; op++) begin
      run_op("R11", 3'(op), 5'd3, 5'd4, 1'b0, 1'b0);
      chk("R11", {res_zero_o, div_err_o, res_exp_o, res_tup_o}, 12'h800);
    end
  endtask

  task automatic t_hold();
    logic [12:0] held;
    // R2
    run_op("R2", 3'd0, 5'd2, 5'd3, 1'b0, 1'b0);
    held = outs();
    chk("R2", held, model(3'd0, 5'd2, 5'd3, 1'b0, 1'b0));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      op_i = 3'd1; a_i = 5'(i + 9); b_i = 5'd1; b_zero_i = 1'b1;
      @(negedge clk_i);
      chk("R2", outs(), {1'b0, held[11:0]});
    end
    b_zero_i = 1'b0;
  endtask

  task automatic t_range();
    // R12
    for (int a = 0; a < 32; a++) begin
      run_op("R12", 3'd2, 5'(a), 5'd1, 1'b0, 1'b0);
      chk("R12", {res_exp_o <= 5'd30, res_zero_o || res_tup_o != 0}, 2'b11);
    end
  endtask

  initial begin
    logic [5:0] t;
    t = 6'd1;
    for (int i = 0; i < 31; i++) begin
      pw[i] = t[4:0];
      t = t << 1;
      if (t[5]) t = t ^ 6'b100101;
    end
  end

  initial begin
    #1;
    t_reset();
    t_mul();
    t_div();
    t_add();
    t_log();
    t_alog();
    t_wrap();
    t_zero();
    t_div0();
    t_badop();
    t_hold();
    t_range();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule